// File: doc/BRIEF.md
# Multi-width integer register file

This block holds the sixteen 64-bit integer registers of a processor core and lets instructions reach them through narrower views. An operand is named by a 4-bit register index, a 2-bit view selector and a prefix-present flag. The view picks the whole register, its low 32 bits, its low 16 bits or a single byte. Bit 3 of the index is the extension bit carried by an instruction prefix, so registers 8 to 15 can only be named when a prefix is present and the core runs in the wide mode.

There are two combinational read ports and one write port that updates on the rising clock edge. A narrow write merges its data into the selected register, except that a 32-bit write clears the upper half. Each port decodes its operand on its own and raises an error flag when the combination is illegal in the current mode. An illegal write is dropped, and an illegal read returns zero.

Top module: `multiwidth_regfile`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all sixteen registers to zero.
- R2: View encoding is 2'b00 full 64 bits, 2'b01 low 32 bits, 2'b10 low 16 bits and 2'b11 byte. Reads return the selected field zero-extended to 64 bits.
- R3: A write through the 32-bit view stores wr_data[31:0] in bits 31:0 and clears bits 63:32.
- R4: A write through the 16-bit view replaces bits 15:0 only. A write through a byte view replaces the selected byte only. All other bits keep their old values.
- R5: With the byte view and pfx=0, index 0 to 3 selects bits 7:0 of registers 0 to 3, and index 4 to 7 selects bits 15:8 of registers 0 to 3.
- R6: With the byte view and pfx=1, index n selects bits 7:0 of register n for every n from 0 to 15.
- R7: An operand with index bit 3 set and pfx=0 is illegal.
- R8: When long_mode=0, any operand with pfx=1 or the full view is illegal, so only the eight legacy registers can be reached.
- R9: An illegal operand raises that port's error output in the same cycle. An illegal write changes no register, and an illegal read returns zero.
- R10: A read of a register in the same cycle as a write to it returns the old value. The new value is visible after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| long_mode | input | 1 | 1 = wide mode, where prefixes and the full view are allowed |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index; bit 3 is the prefix extension bit |
| wr_view | input | 2 | Write view selector |
| wr_pfx | input | 1 | A prefix is present on the write operand |
| wr_data | input | 64 | Write data, right-justified |
| wr_err | output | 1 | Write operand is illegal (only while wr_en is high) |
| rd0_idx | input | 4 | Read port 0 index |
| rd0_view | input | 2 | Read port 0 view |
| rd0_pfx | input | 1 | Read port 0 prefix present |
| rd0_data | output | 64 | Read port 0 data, zero-extended |
| rd0_err | output | 1 | Read port 0 operand is illegal |
| rd1_idx | input | 4 | Read port 1 index |
| rd1_view | input | 2 | Read port 1 view |
| rd1_pfx | input | 1 | Read port 1 prefix present |
| rd1_data | output | 64 | Read port 1 data, zero-extended |
| rd1_err | output | 1 | Read port 1 operand is illegal |

## Verification
On every cycle, the assertions check the following. An illegal read returns zero. An illegal write leaves its target register intact. A 32-bit write leaves the upper half clear. A 16-bit write keeps the upper 48 bits. In legacy mode no write lands in registers 8 to 15. Only the bench scenarios can show the rest: the exact byte-lane mapping with and without a prefix, the merged values after a chain of narrow writes, the read of the old value while a write is pending, and the clearing effect of reset.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
    parameter int XLEN  = 64;
    parameter int IDX_W = 4;
    localparam int NREGS = 1 << IDX_W;

    typedef enum logic [1:0] {
        VIEW_FULL = 2'b00,
        VIEW_DW   = 2'b01,
        VIEW_W    = 2'b10,
        VIEW_BYTE = 2'b11
    } view_e;

    typedef struct packed {
        logic [IDX_W-1:0] phys;
        view_e            view;
        logic             hi;
        logic             err;
    } opnd_t;

    function automatic logic [XLEN-1:0] zext16(input logic [15:0] v);
        return {{(XLEN-16){1'b0}}, v};
    endfunction
endpackage

// File: rtl/rf_operand_decode.sv
module rf_operand_decode
    import regfile_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       view,
    input  logic             pfx,
    input  logic             long_mode,
    output opnd_t            opnd
);
    logic legacy_hi;

    always_comb begin
        legacy_hi  = (view == VIEW_BYTE) && !pfx && idx[2];
        opnd.view  = view_e'(view);
        opnd.hi    = legacy_hi;
        opnd.phys  = legacy_hi ? {2'b00, idx[1:0]} : idx;
        opnd.err   = (idx[IDX_W-1] && !pfx)
                   || (!long_mode && (pfx || view == VIEW_FULL));
    end
endmodule

// File: rtl/rf_read_lane.sv
module rf_read_lane
    import regfile_pkg::*;
(
    input  logic [XLEN-1:0] reg_val,
    input  opnd_t           opnd,
    output logic [XLEN-1:0] data
);
    always_comb begin
        if (opnd.err) begin
            data = '0;
        end else begin
            unique case (opnd.view)
                VIEW_FULL: data = reg_val;
                VIEW_DW:   data = {{(XLEN-32){1'b0}}, reg_val[31:0]};
                VIEW_W:    data = zext16(reg_val[15:0]);
                default:   data = zext16({8'h00, opnd.hi ? reg_val[15:8] : reg_val[7:0]});
            endcase
        end
    end
endmodule

// File: rtl/rf_write_merge.sv
module rf_write_merge
    import regfile_pkg::*;
(
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] wdata,
    input  opnd_t           opnd,
    output logic [XLEN-1:0] new_val
);
    always_comb begin
        new_val = old_val;
        unique case (opnd.view)
            VIEW_FULL: new_val = wdata;
            VIEW_DW:   new_val = {{(XLEN-32){1'b0}}, wdata[31:0]};
            VIEW_W:    new_val[15:0] = wdata[15:0];
            default: begin
                if (opnd.hi) new_val[15:8] = wdata[7:0];
                else         new_val[7:0]  = wdata[7:0];
            end
        endcase
    end
endmodule

// File: rtl/multiwidth_regfile.sv
module multiwidth_regfile
    import regfile_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             long_mode,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_view,
    input  logic             wr_pfx,
    input  logic [XLEN-1:0]  wr_data,
    output logic             wr_err,
    input  logic [IDX_W-1:0] rd0_idx,
    input  logic [1:0]       rd0_view,
    input  logic             rd0_pfx,
    output logic [XLEN-1:0]  rd0_data,
    output logic             rd0_err,
    input  logic [IDX_W-1:0] rd1_idx,
    input  logic [1:0]       rd1_view,
    input  logic             rd1_pfx,
    output logic [XLEN-1:0]  rd1_data,
    output logic             rd1_err
);
    localparam int NRD = 2;

    logic [XLEN-1:0]  regs [NREGS];
    logic [IDX_W-1:0] rd_idx  [NRD];
    logic [1:0]       rd_view [NRD];
    logic             rd_pfx  [NRD];
    logic [XLEN-1:0]  rd_data [NRD];
    opnd_t            rd_op   [NRD];
    opnd_t            wr_op;
    logic [XLEN-1:0]  merged;
    logic             wr_fire;

    assign rd_idx[0]  = rd0_idx;
    assign rd_idx[1]  = rd1_idx;
    assign rd_view[0] = rd0_view;
    assign rd_view[1] = rd1_view;
    assign rd_pfx[0]  = rd0_pfx;
    assign rd_pfx[1]  = rd1_pfx;

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        rf_operand_decode u_dec (
            .idx(rd_idx[p]), .view(rd_view[p]), .pfx(rd_pfx[p]),
            .long_mode(long_mode), .opnd(rd_op[p])
        );
        rf_read_lane u_lane (
            .reg_val(regs[rd_op[p].phys]), .opnd(rd_op[p]), .data(rd_data[p])
        );
    end

    assign rd0_data = rd_data[0];
    assign rd1_data = rd_data[1];
    assign rd0_err  = rd_op[0].err;
    assign rd1_err  = rd_op[1].err;

    rf_operand_decode u_wdec (
        .idx(wr_idx), .view(wr_view), .pfx(wr_pfx),
        .long_mode(long_mode), .opnd(wr_op)
    );

    rf_write_merge u_merge (
        .old_val(regs[wr_op.phys]), .wdata(wr_data), .opnd(wr_op), .new_val(merged)
    );

    assign wr_err  = wr_en && wr_op.err;
    assign wr_fire = wr_en && !wr_op.err;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (wr_fire) begin
            regs[wr_op.phys] <= merged;
        end
    end

    // R9: illegal reads produce zero
    assert_err_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rd0_err |-> rd0_data == '0) and (rd1_err |-> rd1_data == '0));

    // R9: an illegal write leaves its target untouched
    assert_bad_write_dropped_R9: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> regs[$past(wr_op.phys)] == $past(regs[wr_op.phys]));

    // R3: 32-bit write clears upper half
    assert_dw_zero_ext_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_err && wr_view == VIEW_DW)
        |=> regs[$past(wr_op.phys)][XLEN-1:32] == '0);

    // R4: 16-bit write keeps upper bits
    assert_w_keeps_upper_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_err && wr_view == VIEW_W)
        |=> regs[$past(wr_op.phys)][XLEN-1:16] == $past(regs[wr_op.phys][XLEN-1:16]));

    // R8: legacy mode never writes the extended registers
    assert_legacy_no_ext_R8: assert property (@(posedge clk) disable iff (rst)
        (!long_mode && wr_en && wr_idx[IDX_W-1]) |-> wr_err);
endmodule

// File: tb/multiwidth_regfile_bench.sv
module multiwidth_regfile_bench;
    logic        clk = 0;
    logic        rst = 1;
    logic        long_mode = 1;
    logic        wr_en = 0;
    logic [3:0]  wr_idx = 0;
    logic [1:0]  wr_view = 0;
    logic        wr_pfx = 0;
    logic [63:0] wr_data = 0;
    logic        wr_err;
    logic [3:0]  rd0_idx = 0, rd1_idx = 0;
    logic [1:0]  rd0_view = 0, rd1_view = 0;
    logic        rd0_pfx = 0, rd1_pfx = 0;
    logic [63:0] rd0_data, rd1_data;
    logic        rd0_err, rd1_err;
    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [1:0] V_Q = 2'b00, V_D = 2'b01, V_W = 2'b10, V_B = 2'b11;

    always #5 clk = ~clk;

    multiwidth_regfile u_multiwidth_regfile (
        .clk(clk), .rst(rst), .long_mode(long_mode),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view), .wr_pfx(wr_pfx),
        .wr_data(wr_data), .wr_err(wr_err),
        .rd0_idx(rd0_idx), .rd0_view(rd0_view), .rd0_pfx(rd0_pfx),
        .rd0_data(rd0_data), .rd0_err(rd0_err),
        .rd1_idx(rd1_idx), .rd1_view(rd1_view), .rd1_pfx(rd1_pfx),
        .rd1_data(rd1_data), .rd1_err(rd1_err)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] i, input logic [1:0] v, input logic p, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1; wr_idx = i; wr_view = v; wr_pfx = p; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input string req, input logic [3:0] i, input logic [1:0] v,
                      input logic p, input logic [63:0] exp);
        rd0_idx = i; rd0_view = v; rd0_pfx = p;
        #1;
        check(req, rd0_data, exp);
    endtask

    task automatic t_reset;
        rd("R1 reg0", 4'd0, V_Q, 1'b1, 64'h0);
        rd("R1 reg15", 4'd15, V_Q, 1'b1, 64'h0);
    endtask

    task automatic t_full_and_views;
        wr(4'd3, V_Q, 1'b0, 64'h0123_4567_89AB_CDEF);
        rd("R2 full", 4'd3, V_Q, 1'b0, 64'h0123_4567_89AB_CDEF);
        rd("R2 dword", 4'd3, V_D, 1'b0, 64'h89AB_CDEF);
        rd("R2 word", 4'd3, V_W, 1'b0, 64'hCDEF);
        rd("R2 byte", 4'd3, V_B, 1'b0, 64'hEF);
        wr(4'd12, V_Q, 1'b1, 64'hCAFE_0000_0000_BEEF);
        rd("R2 ext full", 4'd12, V_Q, 1'b1, 64'hCAFE_0000_0000_BEEF);
    endtask

    task automatic t_merge;
        wr(4'd5, V_Q, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(4'd5, V_D, 1'b0, 64'hAAAA_AAAA_1234_5678);
        rd("R3 zero-ext", 4'd5, V_Q, 1'b0, 64'h0000_0000_1234_5678);
        wr(4'd5, V_Q, 1'b0, 64'h1111_2222_3333_4444);
        wr(4'd5, V_W, 1'b0, 64'hFFFF_FFFF_FFFF_ABCD);
        rd("R4 word merge", 4'd5, V_Q, 1'b0, 64'h1111_2222_3333_ABCD);
        wr(4'd5, V_B, 1'b1, 64'h0000_0000_0000_FF77);
        rd("R4 byte merge", 4'd5, V_Q, 1'b0, 64'h1111_2222_3333_AB77);
    endtask

    task automatic t_legacy_bytes;
        wr(4'd1, V_Q, 1'b0, 64'h8888_7777_6666_5544);
        wr(4'd5, V_B, 1'b0, 64'h99);
        rd("R5 high byte", 4'd1, V_Q, 1'b0, 64'h8888_7777_6666_9944);
        rd("R5 read hi", 4'd5, V_B, 1'b0, 64'h99);
        rd("R5 read lo", 4'd1, V_B, 1'b0, 64'h44);
        rd("R5 reg5 intact", 4'd5, V_Q, 1'b0, 64'h1111_2222_3333_AB77);
    endtask

    task automatic t_prefix_bytes;
        wr(4'd6, V_Q, 1'b0, 64'h0);
        wr(4'd6, V_B, 1'b1, 64'h3C);
        rd("R6 pfx byte6", 4'd6, V_Q, 1'b0, 64'h3C);
        rd("R6 reg2 intact", 4'd2, V_Q, 1'b0, 64'h0);
        wr(4'd13, V_B, 1'b1, 64'hD5);
        rd("R6 pfx byte13", 4'd13, V_B, 1'b1, 64'hD5);
    endtask

    task automatic t_illegal;
        rd0_idx = 4'd12; rd0_view = V_Q; rd0_pfx = 1'b0; #1;
        check("R7 rd err", {63'd0, rd0_err}, 64'd1);
        check("R7 rd zero", rd0_data, 64'h0);
        @(negedge clk);
        wr_en = 1; wr_idx = 4'd12; wr_view = V_Q; wr_pfx = 1'b0; wr_data = 64'h5;
        #1 check("R9 wr err", {63'd0, wr_err}, 64'd1);
        @(posedge clk); #1 wr_en = 0;
        rd("R9 dropped", 4'd12, V_Q, 1'b1, 64'hCAFE_0000_0000_BEEF);
        long_mode = 0;
        rd0_idx = 4'd3; rd0_view = V_D; rd0_pfx = 1'b0; #1;
        check("R8 legacy dword ok", {63'd0, rd0_err}, 64'd0);
        check("R8 legacy dword data", rd0_data, 64'h89AB_CDEF);
        rd0_view = V_Q; #1;
        check("R8 legacy full err", {63'd0, rd0_err}, 64'd1);
        rd0_idx = 4'd9; rd0_view = V_D; rd0_pfx = 1'b1; #1;
        check("R8 legacy pfx err", {63'd0, rd0_err}, 64'd1);
        wr(4'd12, V_D, 1'b1, 64'h7);
        long_mode = 1;
        rd("R8 ext untouched", 4'd12, V_Q, 1'b1, 64'hCAFE_0000_0000_BEEF);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        rd1_idx = 4'd3; rd1_view = V_Q; rd1_pfx = 1'b0;
        wr_en = 1; wr_idx = 4'd3; wr_view = V_Q; wr_pfx = 1'b0; wr_data = 64'h55;
        #1 check("R10 old value", rd1_data, 64'h0123_4567_89AB_CDEF);
        @(posedge clk); #1 wr_en = 0;
        check("R10 new value", rd1_data, 64'h55);
    endtask

    task automatic t_reset_clears;
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        rd("R1 clear reg5", 4'd5, V_Q, 1'b0, 64'h0);
        rd("R1 clear reg12", 4'd12, V_Q, 1'b1, 64'h0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 0;
        t_reset();
        t_full_and_views();
        t_merge();
        t_legacy_bytes();
        t_prefix_bytes();
        t_illegal();
        t_same_cycle();
        t_reset_clears();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule